// File: doc/BRIEF.md
# Frequency-Adaptive Quadrature Signal Generator

This block filters one sampled single-phase signal through a resonant second-order integrator and produces two outputs: a band-pass copy of the input that stays in phase with it, and a low-pass copy that lags it by a quarter period. The resonant centre frequency is not fixed. A frequency-locked loop multiplies the quadrature output by the input error and integrates the product with a negative gain. It then moves the centre frequency until the error product averages to zero, so the generator follows a grid whose frequency drifts.

The block works at sample rate. Each accepted sample strobe starts a three-stage fixed-point pipeline that has one multiplier level per stage. All three outputs update together with a one-cycle output-valid pulse. The damping gain, loop gain, nominal frequency, sample period and the frequency window are inputs that software holds static while the block runs. The block is meant to sit between a voltage-sensing front end and the phase and sequence logic of a grid-tied converter controller.

Top module: `quadFllGen`

## Requirements
- R1: While reset is held and after it is released, before any sample is accepted, `outValid` is low, both signal outputs read zero and `freqOut` equals `freqNominal`.
- R2: A strobe sampled at rising edge n is accepted when the pipeline is idle. `outValid` then goes high after edge n+3 and stays high for exactly one cycle.
- R3: Strobes that arrive while an accepted sample is still in flight are ignored. With the strobe held high continuously, samples are accepted every fourth cycle, so 20 strobe cycles produce exactly 5 output pulses.
- R4: `inPhaseOut`, `quadOut` and `freqOut` change only in the cycle in which `outValid` is high. Between pulses they hold their values.
- R5: Number formats: samples and signal outputs are signed with 15 fraction bits. `gainK` is unsigned with 13 fraction bits. `gainGamma` is unsigned with 16 fraction bits. Frequencies are unsigned rad/s with 8 fraction bits. `samplePeriod` is unsigned seconds with 24 fraction bits. With `gainGamma` at zero, a sine at the nominal frequency gives an in-phase output whose peak is within 10 % of the input peak, and the frequency stays at nominal.
- R6: At the nominal frequency, the quadrature output lags by 90 degrees. At an upward zero crossing of the input, `quadOut` is below -0.85 of the input peak and the magnitude of `inPhaseOut` is below 0.15 of it.
- R7: A zero input keeps both signal outputs at zero and `freqOut` at `freqNominal`, even with a large loop gain.
- R8: The error product is positive when the input is below the centre frequency. With nonzero gamma, a 45 Hz input therefore pulls `freqOut` below 360 rad/s, and a 75 Hz input pushes it above 395 rad/s.
- R9: Every updated `freqOut` is clamped to [`freqMin`, `freqMax`]. A nominal value outside that window is replaced by the nearer limit at the first update, and a loop pulled beyond a limit rests near that limit.
- R10: Accumulators and outputs saturate and never wrap. A full-scale positive DC input with gain k = 3 drives `quadOut` to exactly 32767 and never makes it negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Input sample strobe |
| sampleIn | input | DATA_W | Signed input sample |
| gainK | input | K_W | Damping gain k |
| gainGamma | input | GAMMA_W | Frequency loop gain magnitude |
| freqNominal | input | FREQ_W | Nominal angular frequency |
| samplePeriod | input | TS_W | Sample period |
| freqMin | input | FREQ_W | Lower frequency limit |
| freqMax | input | FREQ_W | Upper frequency limit |
| outValid | output | 1 | One-cycle result strobe |
| inPhaseOut | output | DATA_W | Band-pass in-phase output |
| quadOut | output | DATA_W | Quadrature output |
| freqOut | output | FREQ_W | Frequency estimate |

## Verification
The assertions assume that the configuration inputs change only while reset is held, because a change to `freqNominal` before the first update would otherwise alter `freqOut` without a pulse. The range property also assumes that `freqMin` does not exceed `freqMax`. The stimulus sets every configuration value inside a reset window and always keeps the window ordered. The strobe itself is left unconstrained, and the stimulus deliberately holds it high through busy cycles.

// File: rtl/quadFllPkg.sv
package quadFllPkg;

  localparam int PIPE_STAGES = 3;
  localparam int ACC_V       = 0;
  localparam int ACC_Q       = 1;
  localparam int ACC_COUNT   = 2;

  typedef struct packed {
    logic capture;
    logic multiply;
    logic combine;
    logic commit;
  } stepStrobes_t;

endpackage

// File: rtl/quadFllCtrl.sv
module quadFllCtrl
  import quadFllPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  output stepStrobes_t steps,
  output logic         outValid
);

  logic [PIPE_STAGES-1:0] pipe;
  logic                   busy;
  logic                   accept;

  assign busy   = |pipe;
  assign accept = sampleValid & ~busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe     <= '0;
      outValid <= 1'b0;
    end else begin
      pipe     <= {pipe[PIPE_STAGES-2:0], accept};
      outValid <= pipe[PIPE_STAGES-1];
    end
  end

  always_comb begin
    steps.capture  = accept;
    steps.multiply = pipe[0];
    steps.combine  = pipe[1];
    steps.commit   = pipe[PIPE_STAGES-1];
  end

endmodule

// File: rtl/quadFllSatAccum.sv
module quadFllSatAccum #(
  parameter int W = 19
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  logic signed [W-1:0] delta,
  output logic signed [W-1:0] acc
);

  localparam logic signed [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]   sum;
  logic signed [W-1:0] sumSat;

  assign sum = {acc[W-1], acc} + {delta[W-1], delta};

  always_comb begin
    if (sum[W] != sum[W-1]) sumSat = sum[W] ? ACC_MIN : ACC_MAX;
    else                    sumSat = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   acc <= '0;
    else if (en) acc <= sumSat;
  end

endmodule

// File: rtl/quadFllDatapath.sv
module quadFllDatapath
  import quadFllPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int STATE_W    = 19,
  parameter int K_W        = 16,
  parameter int K_FRAC     = 13,
  parameter int GAMMA_W    = 16,
  parameter int GAMMA_FRAC = 16,
  parameter int FREQ_W     = 24,
  parameter int FREQ_FRAC  = 8,
  parameter int TS_W       = 24,
  parameter int PH_W       = 22,
  parameter int PH_FRAC    = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stepStrobes_t             steps,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [K_W-1:0]           gainK,
  input  logic [GAMMA_W-1:0]       gainGamma,
  input  logic [FREQ_W-1:0]        freqNominal,
  input  logic [TS_W-1:0]          samplePeriod,
  input  logic [FREQ_W-1:0]        freqMin,
  input  logic [FREQ_W-1:0]        freqMax,
  output logic signed [DATA_W-1:0] inPhaseOut,
  output logic signed [DATA_W-1:0] quadOut,
  output logic [FREQ_W-1:0]        freqOut
);

  localparam int WD       = 64;
  localparam int FRAC     = DATA_W - 1;
  localparam int FT_W     = FREQ_W + 2;
  localparam int WTS_SHR  = FREQ_FRAC + TS_W - PH_FRAC;

  typedef logic signed [WD-1:0] wide_t;

  localparam wide_t ST_MAX = (wide_t'(1) <<< (STATE_W-1)) - wide_t'(1);
  localparam wide_t ST_MIN = -(wide_t'(1) <<< (STATE_W-1));
  localparam wide_t FT_MAX = (wide_t'(1) <<< (FT_W-1)) - wide_t'(1);
  localparam wide_t FT_MIN = -(wide_t'(1) <<< (FT_W-1));
  localparam wide_t PH_MAX = (wide_t'(1) <<< PH_W) - wide_t'(1);
  localparam wide_t DO_MAX = (wide_t'(1) <<< (DATA_W-1)) - wide_t'(1);
  localparam wide_t DO_MIN = -(wide_t'(1) <<< (DATA_W-1));

  function automatic logic signed [STATE_W-1:0] satState(input wide_t a);
    if (a > ST_MAX)      return ST_MAX[STATE_W-1:0];
    else if (a < ST_MIN) return ST_MIN[STATE_W-1:0];
    else                 return a[STATE_W-1:0];
  endfunction

  function automatic logic signed [FT_W-1:0] satFterm(input wide_t a);
    if (a > FT_MAX)      return FT_MAX[FT_W-1:0];
    else if (a < FT_MIN) return FT_MIN[FT_W-1:0];
    else                 return a[FT_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] satData(input wide_t a);
    if (a > DO_MAX)      return DO_MAX[DATA_W-1:0];
    else if (a < DO_MIN) return DO_MIN[DATA_W-1:0];
    else                 return a[DATA_W-1:0];
  endfunction

  // integrator states: index ACC_V is the in-phase path, ACC_Q the quadrature path
  logic signed [STATE_W-1:0] accDelta [ACC_COUNT];
  logic signed [STATE_W-1:0] accState [ACC_COUNT];

  logic signed [STATE_W-1:0] errReg, kErrReg, dqReg, fErrReg, dvReg;
  logic signed [FT_W-1:0]    fTermReg;
  logic [PH_W-1:0]           wTsReg;
  logic [FREQ_W-1:0]         freqCur;
  logic                      freqLive;

  logic [FREQ_W-1:0] freqNow;
  wide_t errWide, wTsWide, kErrWide, dqWide, fErrWide, driveWide, dvWide, fTermWide, freqCand;
  logic [PH_W-1:0]   wTsSat;
  logic [FREQ_W-1:0] freqNext;

  assign freqNow = freqLive ? freqCur : freqNominal;

  assign accDelta[ACC_V] = dvReg;
  assign accDelta[ACC_Q] = dqReg;

  for (genvar g = 0; g < ACC_COUNT; g++) begin : g_accum
    quadFllSatAccum #(.W(STATE_W)) u_accum (
      .clk   (clk),
      .rstN  (rstN),
      .en    (steps.commit),
      .delta (accDelta[g]),
      .acc   (accState[g])
    );
  end

  // stage 1: error against in-phase state, and frequency times sample period
  always_comb begin
    errWide = wide_t'(sampleIn) - wide_t'(accState[ACC_V]);
    wTsWide = (wide_t'(freqNow) * wide_t'(samplePeriod)) >>> WTS_SHR;
    wTsSat  = (wTsWide > PH_MAX) ? PH_MAX[PH_W-1:0] : wTsWide[PH_W-1:0];
  end

  // stage 2: k*error, quadrature increment, frequency error product
  always_comb begin
    kErrWide = (wide_t'(errReg) * wide_t'(gainK)) >>> K_FRAC;
    dqWide   = (wide_t'(accState[ACC_V]) * wide_t'(wTsReg)) >>> PH_FRAC;
    fErrWide = (wide_t'(accState[ACC_Q]) * wide_t'(errReg)) >>> FRAC;
  end

  // stage 3: in-phase increment and scaled frequency correction
  always_comb begin
    driveWide = wide_t'(kErrReg) - wide_t'(accState[ACC_Q]);
    dvWide    = (driveWide * wide_t'(wTsReg)) >>> PH_FRAC;
    fTermWide = (wide_t'(fErrReg) * wide_t'(gainGamma)) >>> GAMMA_FRAC;
  end

  // stage 4: negative-gain integration of the frequency, clamped to the window
  always_comb begin
    freqCand = wide_t'(freqNow) - wide_t'(fTermReg);
    if (freqCand < wide_t'(freqMin))      freqNext = freqMin;
    else if (freqCand > wide_t'(freqMax)) freqNext = freqMax;
    else                                  freqNext = freqCand[FREQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg   <= '0;
      wTsReg   <= '0;
      kErrReg  <= '0;
      dqReg    <= '0;
      fErrReg  <= '0;
      dvReg    <= '0;
      fTermReg <= '0;
      freqCur  <= '0;
      freqLive <= 1'b0;
    end else begin
      if (steps.capture) begin
        errReg <= satState(errWide);
        wTsReg <= wTsSat;
      end
      if (steps.multiply) begin
        kErrReg <= satState(kErrWide);
        dqReg   <= satState(dqWide);
        fErrReg <= satState(fErrWide);
      end
      if (steps.combine) begin
        dvReg    <= satState(dvWide);
        fTermReg <= satFterm(fTermWide);
      end
      if (steps.commit) begin
        freqCur  <= freqNext;
        freqLive <= 1'b1;
      end
    end
  end

  assign inPhaseOut = satData(wide_t'(accState[ACC_V]));
  assign quadOut    = satData(wide_t'(accState[ACC_Q]));
  assign freqOut    = freqNow;

endmodule

// File: rtl/quadFllGen.sv
module quadFllGen
  import quadFllPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HEADROOM   = 3,
  parameter int K_W        = 16,
  parameter int K_FRAC     = 13,
  parameter int GAMMA_W    = 16,
  parameter int GAMMA_FRAC = 16,
  parameter int FREQ_W     = 24,
  parameter int FREQ_FRAC  = 8,
  parameter int TS_W       = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [K_W-1:0]           gainK,
  input  logic [GAMMA_W-1:0]       gainGamma,
  input  logic [FREQ_W-1:0]        freqNominal,
  input  logic [TS_W-1:0]          samplePeriod,
  input  logic [FREQ_W-1:0]        freqMin,
  input  logic [FREQ_W-1:0]        freqMax,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] inPhaseOut,
  output logic signed [DATA_W-1:0] quadOut,
  output logic [FREQ_W-1:0]        freqOut
);

  localparam int STATE_W = DATA_W + HEADROOM;
  localparam int PH_FRAC = TS_W - 4;
  localparam int PH_W    = PH_FRAC + 2;

  stepStrobes_t steps;

  quadFllCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .steps       (steps),
    .outValid    (outValid)
  );

  quadFllDatapath #(
    .DATA_W     (DATA_W),
    .STATE_W    (STATE_W),
    .K_W        (K_W),
    .K_FRAC     (K_FRAC),
    .GAMMA_W    (GAMMA_W),
    .GAMMA_FRAC (GAMMA_FRAC),
    .FREQ_W     (FREQ_W),
    .FREQ_FRAC  (FREQ_FRAC),
    .TS_W       (TS_W),
    .PH_W       (PH_W),
    .PH_FRAC    (PH_FRAC)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .steps        (steps),
    .sampleIn     (sampleIn),
    .gainK        (gainK),
    .gainGamma    (gainGamma),
    .freqNominal  (freqNominal),
    .samplePeriod (samplePeriod),
    .freqMin      (freqMin),
    .freqMax      (freqMax),
    .inPhaseOut   (inPhaseOut),
    .quadOut      (quadOut),
    .freqOut      (freqOut)
  );

endmodule

// File: rtl/quadFllChecker.sv
module quadFllChecker #(
  parameter int DATA_W = 16,
  parameter int FREQ_W = 24
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] inPhaseOut,
  input logic signed [DATA_W-1:0] quadOut,
  input logic [FREQ_W-1:0]        freqOut,
  input logic [FREQ_W-1:0]        freqMin,
  input logic [FREQ_W-1:0]        freqMax
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN) outValid |-> $past(sampleValid, 4)); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN) outValid |=> !outValid); // R3

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> ($stable(inPhaseOut) && $stable(quadOut) && $stable(freqOut))); // R4

  AST_FREQ_RANGE: assert property (@(posedge clk) disable iff (!rstN) (outValid && (freqMin <= freqMax)) |-> ((freqOut >= freqMin) && (freqOut <= freqMax))); // R9

endmodule

bind quadFllGen quadFllChecker #(.DATA_W(DATA_W), .FREQ_W(FREQ_W)) u_quadFllChecker (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .outValid    (outValid),
  .inPhaseOut  (inPhaseOut),
  .quadOut     (quadOut),
  .freqOut     (freqOut),
  .freqMin     (freqMin),
  .freqMax     (freqMax)
);

// File: tb/test_quadFllGen.sv
`timescale 1ns/1ps
module test_quadFllGen;

  localparam int K_NOM   = 11585;   // 1.414 with 13 fraction bits
  localparam int TS_CODE = 1678;    // 100 us with 24 fraction bits
  localparam int F_NOM   = 96510;   // 2*pi*60 rad/s, 8 fraction bits
  localparam int F_40    = 64340;
  localparam int F_55    = 88468;
  localparam int F_80    = 128680;
  localparam int AMP     = 16384;   // 0.5 full scale
  localparam real TS_SEC = 1.0e-4;
  localparam real TWO_PI = 6.283185307179586;

  // scenario table: input frequency, loop gain, window, sample count, expected final frequency band
  localparam int ROWS = 4;
  localparam int ROW_HZ    [ROWS] = '{60, 45, 75, 45};
  localparam int ROW_GAMMA [ROWS] = '{0, 2000, 2000, 8000};
  localparam int ROW_MIN   [ROWS] = '{F_40, F_40, F_40, F_55};
  localparam int ROW_MAX   [ROWS] = '{F_80, F_80, F_80, F_80};
  localparam int ROW_N     [ROWS] = '{1000, 2500, 2500, 2500};
  localparam int ROW_LO    [ROWS] = '{F_NOM, F_40, 101120, F_55};
  localparam int ROW_HI    [ROWS] = '{F_NOM, 92160, F_80, 94720};

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic [15:0]        cfgK = '0;
  logic [15:0]        cfgGamma = '0;
  logic [23:0]        cfgNom = '0;
  logic [23:0]        cfgTs = '0;
  logic [23:0]        cfgMin = '0;
  logic [23:0]        cfgMax = '0;
  logic               outValid;
  logic signed [15:0] inPhaseOut;
  logic signed [15:0] quadOut;
  logic [23:0]        freqOut;

  int nChecks = 0;
  int nBad = 0;
  int protoErr = 0;
  int lastV, lastQ, lastF;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  quadFllGen i_quadFllGen (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sampleIn     (sampleIn),
    .gainK        (cfgK),
    .gainGamma    (cfgGamma),
    .freqNominal  (cfgNom),
    .samplePeriod (cfgTs),
    .freqMin      (cfgMin),
    .freqMax      (cfgMax),
    .outValid     (outValid),
    .inPhaseOut   (inPhaseOut),
    .quadOut      (quadOut),
    .freqOut      (freqOut)
  );

  task automatic checkIn(input string tag, input int actual, input int lo, input int hi);
    nChecks++;
    if (actual < lo || actual > hi) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=[%0d..%0d]", tag, actual, lo, hi);
    end
  endtask

  task automatic applyReset(input int k, input int gamma, input int fmin, input int fmax);
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    sampleIn = '0;
    cfgK = k[15:0];
    cfgGamma = gamma[15:0];
    cfgNom = F_NOM[23:0];
    cfgTs = TS_CODE[23:0];
    cfgMin = fmin[23:0];
    cfgMax = fmax[23:0];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // strobe at one edge, read results after the third edge that follows
  task automatic sendSample(input int val);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = val[15:0];
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    if (!outValid) protoErr++;
    lastV = int'(inPhaseOut);
    lastQ = int'(quadOut);
    lastF = int'(freqOut);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int pulses;
    int hv, hq, hf;
    bit holdOk;

    // ---------- R1: reset state ----------
    applyReset(K_NOM, 0, F_40, F_80);
    checkIn("R1 outValid", int'(outValid), 0, 0);
    checkIn("R1 inPhaseOut", int'(inPhaseOut), 0, 0);
    checkIn("R1 quadOut", int'(quadOut), 0, 0);
    checkIn("R1 freqOut", int'(freqOut), F_NOM, F_NOM);

    // ---------- scenario table ----------
    for (int r = 0; r < ROWS; r++) begin
      int maxV, maxQ, crossV, crossQ, protoStart;
      real cyc, prevCyc;
      applyReset(K_NOM, ROW_GAMMA[r], ROW_MIN[r], ROW_MAX[r]);
      protoStart = protoErr;
      maxV = 0; maxQ = 0; crossV = 0; crossQ = 0;
      prevCyc = -1.0;
      for (int n = 0; n < ROW_N[r]; n++) begin
        cyc = real'(n) * real'(ROW_HZ[r]) * TS_SEC;
        sendSample($rtoi(real'(AMP) * $sin(TWO_PI * cyc)));
        if (n > ROW_N[r] - 200) begin
          if (lastV > maxV) maxV = lastV;
          if (lastQ > maxQ) maxQ = lastQ;
          if ($floor(cyc) != $floor(prevCyc)) begin
            crossV = lastV;
            crossQ = lastQ;
          end
        end
        prevCyc = cyc;
      end
      checkIn("R2 pulse per accepted sample", protoErr - protoStart, 0, 0);
      checkIn(r == 0 ? "R5 freq held at nominal" : (r == 3 ? "R9 freq rests at lower limit" : "R8 freq pulled toward input"),
              lastF, ROW_LO[r], ROW_HI[r]);
      if (r == 0) begin
        checkIn("R5 in-phase peak", maxV, 14746, 18022);
        checkIn("R6 quadrature peak", maxQ, 14746, 18022);
        checkIn("R6 quadrature at upward crossing", crossQ, -32768, -13926);
        checkIn("R6 in-phase at upward crossing", crossV, -2458, 2458);
      end
    end

    // ---------- R2: exact latency ----------
    applyReset(K_NOM, 0, F_40, F_80);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = 16'sd1000;
    @(negedge clk);
    sampleValid = 1'b0;
    checkIn("R2 low after edge n", int'(outValid), 0, 0);
    @(negedge clk);
    checkIn("R2 low after edge n+1", int'(outValid), 0, 0);
    @(negedge clk);
    checkIn("R2 low after edge n+2", int'(outValid), 0, 0);
    @(negedge clk);
    checkIn("R2 high after edge n+3", int'(outValid), 1, 1);
    @(negedge clk);
    checkIn("R2 single cycle", int'(outValid), 0, 0);

    // ---------- R4: outputs hold between pulses ----------
    hv = int'(inPhaseOut); hq = int'(quadOut); hf = int'(freqOut);
    holdOk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (int'(inPhaseOut) != hv || int'(quadOut) != hq || int'(freqOut) != hf || outValid) holdOk = 1'b0;
    end
    checkIn("R4 outputs held without pulse", int'(holdOk), 1, 1);
    checkIn("R4 in-phase moved by the sample", hv, 1, 32767);

    // ---------- R3: strobes while busy are ignored ----------
    applyReset(K_NOM, 0, F_40, F_80);
    pulses = 0;
    sampleIn = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (outValid) pulses++;
      sampleValid = (i < 20);
    end
    sampleValid = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (outValid) pulses++;
    end
    checkIn("R3 pulses for 20 strobe cycles", pulses, 5, 5);

    // ---------- R7: zero input stays quiet ----------
    applyReset(K_NOM, 8000, F_40, F_80);
    for (int n = 0; n < 50; n++) sendSample(0);
    checkIn("R7 in-phase zero", lastV, 0, 0);
    checkIn("R7 quadrature zero", lastQ, 0, 0);
    checkIn("R7 freq nominal", lastF, F_NOM, F_NOM);

    // ---------- R9: nominal outside the window ----------
    applyReset(K_NOM, 0, F_NOM + 2560, F_80);
    checkIn("R9 before first update", int'(freqOut), F_NOM, F_NOM);
    sendSample(0);
    checkIn("R9 raised to lower limit", lastF, F_NOM + 2560, F_NOM + 2560);
    applyReset(K_NOM, 0, F_40, F_NOM - 2560);
    sendSample(0);
    checkIn("R9 lowered to upper limit", lastF, F_NOM - 2560, F_NOM - 2560);

    // ---------- R10: saturation without wrap ----------
    applyReset(24576, 0, F_40, F_80);
    begin
      int minQ = 0;
      for (int n = 0; n < 600; n++) begin
        sendSample(32767);
        if (lastQ < minQ) minQ = lastQ;
      end
      checkIn("R10 quadrature saturates", lastQ, 32767, 32767);
      checkIn("R10 quadrature never wraps negative", minQ, 0, 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule